// File: doc/BRIEF.md
# Prioritized Multi-Converter Interrupt Reader

This block collects results from several 8-bit converters. Each converter signals a finished conversion on its own active-low done line. While the block is idle, any done line going low makes it latch all done lines into an active-low status byte. Bits above the converter count in that byte are held at 1 and are never serviced.

The block then works through the converters marked in that byte, lowest converter number first. For each one it pulses that converter's read enable for one cycle and samples the shared data bus. It writes the sample to memory and, in the next cycle, writes a tag byte that names the converter at the next higher address. The write pointer keeps running across service passes. Requests that arrive after the snapshot is taken are handled in the pass that follows.

Top module: `conv_irq_collector`

## Requirements
- R1: After reset, busy, mem_we and every rd_en bit are low, and the first data byte written goes to address BASE_ADDR.
- R2: While idle, a low level on any done_n bit (bit i belongs to converter i+1) is latched, and busy is high one cycle later.
- R3: Within a pass, each converter whose done_n bit was low in the latched snapshot is read exactly once, and no other converter is read.
- R4: Converters are read in ascending converter number, so converter 1 is read first and converter 7 last, whatever order their requests arrived in.
- R5: A converter's data byte is written at address A. The tag byte follows in the very next cycle at address A+1.
- R6: The tag byte is the converter number, 1 to 7, as an unsigned 8-bit value.
- R7: The write address advances by 2 for each converter serviced. It carries on from pass to pass and wraps modulo 2^ADDR_W.
- R8: A done_n bit that falls after the snapshot is not read in the current pass. It is serviced in the next pass.
- R9: busy stays high from the cycle after capture through the cycle of the last tag write, then drops. While busy is low, mem_we and rd_en are low.
- R10: At most one rd_en bit is high at a time, and only for a single cycle. The sampled byte is written in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| done_n | input | N_CONV | Active-low conversion-done lines; bit i is converter i+1 |
| rd_en | output | N_CONV | One-cycle read strobe to the selected converter |
| rd_data | input | 8 | Shared converter data bus, valid while rd_en is high |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | 8 | Memory write data (sample or tag) |
| busy | output | 1 | High while a service pass is in progress |

## Verification
The assertions check the per-cycle rules on every cycle: a single read strobe at a time, a write in the cycle after each read, a tag written one address above its sample with a value in range, busy rising only after a request, and a quiet bus while idle. They cannot tell which converters were chosen, in what order, or where the pointer lands after several passes. The bench covers those by sweeping every non-empty request pattern of the seven converters and checking the full write log against the expected order, data, tags and addresses. It also adds one case with a late request, which must land in the following pass.

// File: rtl/conv_irq_pkg.sv
package conv_irq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PICK,
        ST_READ,
        ST_WDAT,
        ST_WTAG
    } svc_state_e;

    localparam int DATA_W = 8;

    function automatic logic [DATA_W-1:0] conv_tag(input int idx);
        return DATA_W'(idx + 1);
    endfunction

endpackage

// File: rtl/conv_snap.sv
module conv_snap #(
    parameter int N_CONV = 7,
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap,
    input  logic [N_CONV-1:0] done_n,
    input  logic              clr,
    input  logic [N_CONV-1:0] clr_oh,
    output logic [N_CONV-1:0] pend
);
    localparam int PAD_W = STAT_W - N_CONV;

    // active-low status latch; padding bits held inactive
    logic [STAT_W-1:0] status_q;

    always_ff @(posedge clk) begin
        if (rst)
            status_q <= '1;
        else if (cap)
            status_q <= {{PAD_W{1'b1}}, done_n};
        else if (clr)
            status_q <= status_q | {{PAD_W{1'b0}}, clr_oh};
    end

    assign pend = ~status_q[N_CONV-1:0];
endmodule

// File: rtl/conv_pick.sv
module conv_pick #(
    parameter int N_CONV = 7,
    parameter int IDX_W  = 3
) (
    input  logic [N_CONV-1:0] pend,
    output logic [N_CONV-1:0] sel_oh,
    output logic [IDX_W-1:0]  sel_idx
);
    // lowest set bit wins
    logic [N_CONV-1:0] above;

    genvar g;
    generate
        for (g = 0; g < N_CONV; g++) begin : g_pri
            if (g == 0) begin : g_first
                assign above[g] = 1'b0;
            end else begin : g_rest
                assign above[g] = above[g-1] | pend[g-1];
            end
            assign sel_oh[g] = pend[g] & ~above[g];
        end
    endgenerate

    always_comb begin
        sel_idx = '0;
        for (int i = 0; i < N_CONV; i++)
            if (sel_oh[i]) sel_idx = IDX_W'(i);
    end
endmodule

// File: rtl/conv_irq_collector.sv
module conv_irq_collector
    import conv_irq_pkg::*;
#(
    parameter int               N_CONV    = 7,
    parameter int               ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_CONV-1:0] done_n,
    output logic [N_CONV-1:0] rd_en,
    input  logic [7:0]        rd_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              busy
);
    localparam int STAT_W = ((N_CONV + 8) / 8) * 8;
    localparam int IDX_W  = (N_CONV > 1) ? $clog2(N_CONV) : 1;

    svc_state_e          st_q;
    logic [N_CONV-1:0]   pend, pick_oh, cur_oh_q;
    logic [IDX_W-1:0]    pick_idx, cur_idx_q;
    logic [7:0]          data_q;
    logic [ADDR_W-1:0]   ptr_q;
    logic                cap, clr;

    assign cap = (st_q == ST_IDLE) && (done_n != '1);
    assign clr = (st_q == ST_WTAG);

    conv_snap #(.N_CONV(N_CONV), .STAT_W(STAT_W)) u_snap (
        .clk(clk), .rst(rst), .cap(cap), .done_n(done_n),
        .clr(clr), .clr_oh(cur_oh_q), .pend(pend)
    );

    conv_pick #(.N_CONV(N_CONV), .IDX_W(IDX_W)) u_pick (
        .pend(pend), .sel_oh(pick_oh), .sel_idx(pick_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            cur_oh_q  <= '0;
            cur_idx_q <= '0;
            data_q    <= '0;
            ptr_q     <= BASE_ADDR;
        end else begin
            case (st_q)
                ST_IDLE: if (cap) st_q <= ST_PICK;
                ST_PICK: begin
                    cur_oh_q  <= pick_oh;
                    cur_idx_q <= pick_idx;
                    st_q      <= (pend == '0) ? ST_IDLE : ST_READ;
                end
                ST_READ: begin
                    data_q <= rd_data;
                    st_q   <= ST_WDAT;
                end
                ST_WDAT: st_q <= ST_WTAG;
                ST_WTAG: begin
                    ptr_q <= ptr_q + ADDR_W'(2);
                    st_q  <= ((pend & ~cur_oh_q) == '0) ? ST_IDLE : ST_PICK;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        rd_en     = (st_q == ST_READ) ? cur_oh_q : '0;
        mem_we    = (st_q == ST_WDAT) || (st_q == ST_WTAG);
        mem_addr  = (st_q == ST_WTAG) ? ptr_q + ADDR_W'(1) : ptr_q;
        mem_wdata = (st_q == ST_WTAG) ? conv_tag(int'(cur_idx_q)) : data_q;
        busy      = (st_q != ST_IDLE);
    end
endmodule

// File: rtl/conv_irq_collector_chk.sv
module conv_irq_collector_chk #(
    parameter int N_CONV = 7,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [N_CONV-1:0] done_n,
    input logic [N_CONV-1:0] rd_en,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_wdata,
    input logic              busy
);
    AST_RD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rd_en)); // R10
    AST_RD_THEN_WRITE: assert property (@(posedge clk) disable iff (rst)
        (rd_en != '0) |=> (mem_we && rd_en == '0)); // R10
    AST_NO_RD_WHILE_WE: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (rd_en == '0)); // R10
    AST_TAG_ADDR_NEXT: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1))); // R5
    AST_TAG_RANGE: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> (mem_wdata >= 8'd1 && mem_wdata <= 8'(N_CONV))); // R6
    AST_BUSY_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(done_n) != '1)); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_we && rd_en == '0)); // R9
endmodule

bind conv_irq_collector conv_irq_collector_chk #(.N_CONV(N_CONV), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .done_n(done_n), .rd_en(rd_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy)
);

// File: tb/test_conv_irq_collector.sv
module test_conv_irq_collector;
    localparam int N = 7;
    localparam logic [7:0] BASE = 8'h40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0] armed = '0;
    logic [N-1:0] done_n, rd_en;
    logic [7:0] rd_data, mem_addr, mem_wdata;
    logic mem_we, busy;

    int total = 0, bad = 0, pass_id = 0, log_n = 0, rd_multi = 0;
    logic [7:0] log_a [0:15];
    logic [7:0] log_d [0:15];
    logic [7:0] exp_ptr = BASE;
    int cycles = 0;

    always #4 clk = ~clk;

    assign done_n = ~armed;

    conv_irq_collector #(.N_CONV(N), .ADDR_W(8), .BASE_ADDR(BASE)) i_conv_irq_collector (
        .clk(clk), .rst(rst), .done_n(done_n), .rd_en(rd_en), .rd_data(rd_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy)
    );

    function automatic logic [7:0] cv(input int i, input int p);
        return 8'(i * 37 + p * 11 + 5);
    endfunction

    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < N; i++)
            if (rd_en[i]) rd_data = cv(i, pass_id);
    end

    // converter model: a read clears its request
    always @(posedge clk)
        for (int i = 0; i < N; i++)
            if (rd_en[i]) armed[i] <= 1'b0;

    always @(negedge clk) begin
        cycles <= cycles + 1;
        if ($countones(rd_en) > 1) rd_multi <= rd_multi + 1;
        if (mem_we && !rst) begin
            if (log_n < 16) begin
                log_a[log_n] <= mem_addr;
                log_d[log_n] <= mem_wdata;
            end
            log_n <= log_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic wait_idle();
        int t = 0;
        while (busy && t < 300) begin
            @(negedge clk);
            t++;
        end
        chk(!busy, "R9 busy drops", busy, 0);
    endtask

    task automatic compare(input logic [N-1:0] mask);
        int k = 0;
        chk(log_n == 2 * $countones(mask), "R3 write count", log_n, 2 * $countones(mask));
        for (int i = 0; i < N; i++) begin
            if (mask[i] && k + 1 < 16 && k + 1 < log_n) begin
                chk(log_a[k] == exp_ptr && log_d[k] == cv(i, pass_id),
                    "R4 R5 R7 data order/addr", {log_a[k], log_d[k]}, {exp_ptr, cv(i, pass_id)});
                chk(log_a[k+1] == 8'(exp_ptr + 1) && log_d[k+1] == 8'(i + 1),
                    "R6 R5 tag", {log_a[k+1], log_d[k+1]}, {8'(exp_ptr + 1), 8'(i + 1)});
            end
            if (mask[i]) begin
                k += 2;
                exp_ptr = 8'(exp_ptr + 2);
            end
        end
    endtask

    task automatic run_pass(input logic [N-1:0] mask, input logic [N-1:0] late);
        log_n = 0;
        armed = armed | mask;
        @(negedge clk);
        chk(busy == 1'b1, "R2 busy after request", busy, 1);
        if (late != '0) armed = armed | late;
        wait_idle();
        compare(mask);
        if (late != '0) begin
            chk(armed == late, "R8 late request still pending", armed, late);
            log_n = 0;
            @(negedge clk);
            chk(busy == 1'b1, "R8 second pass starts", busy, 1);
            wait_idle();
            compare(late);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && mem_we == 1'b0 && rd_en == '0, "R1 reset state",
            {busy, mem_we, rd_en}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R1 idle without request", busy, 0);
        for (int m = 1; m < (1 << N); m++) begin
            pass_id = m;
            run_pass(N'(m), '0);
        end
        pass_id = 200;
        run_pass(7'b0000101, 7'b1000000);
        chk(rd_multi == 0, "R10 single read strobe", rd_multi, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule